// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers event pulses for a two-wire serial bus controller and turns them into one interrupt line. Each source lands in a sticky status bit that stays set until software writes a 1 to it. A separate mask decides which set bits may raise the interrupt. Software changes the mask through two write-only ports: an unmask port and a mask port. Each one acts only on the bits written as 1, so no read-modify-write is needed.

Ten bit positions are defined and bit 8 is not used. Position 0 is transfer complete and 1 is data threshold. Positions 2, 3 and 4 are not-acknowledged, timeout and target ready. Positions 5, 6 and 7 are receive overflow, transmit overflow and receive underflow. Position 9 is arbitration lost. The controller core drives the event pulses, and a simple register port with a select, a write strobe and a combinational read does all software access.

Top module: `irq_event_capture`

## Requirements
- R1: After synchronous reset the status reads 0x000, the mask reads 0x2FF (every defined source masked) and irq_o is low.
- R2: A 1 on evt_i[n] for a defined position n (0-7, 9) sets status bit n at the next clock edge, and the bit then stays set while no clear is written.
- R3: A write with reg_sel=0 (status) clears every status bit whose wr_data bit is 1 and leaves bits written as 0 unchanged. Writing 0xFF clears bits 7:0 and leaves bit 9.
- R4: When an event on bit n arrives in the same cycle as a write-1-to-clear of bit n, the bit stays set.
- R5: A write with reg_sel=2 (unmask port) clears each mask bit whose wr_data bit is 1. Mask bits written as 0 keep their value.
- R6: A write with reg_sel=3 (mask port) sets each mask bit whose wr_data bit is 1. Mask bits written as 0 keep their value.
- R7: irq_o is high exactly when some status bit is set while its mask bit is 0. Mask bit 1 means the source is masked.
- R8: Bit 8 and bits 10 and above of both the status (reg_sel=0) and the mask (reg_sel=1) read as zero. Events and writes to those bits have no effect.
- R9: Reads with reg_sel=2 or reg_sel=3 return zero. A write with reg_sel=1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 10 | Single-cycle event pulses, one per status position |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 unmask port, 3 mask port |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| irq_o | output | 1 | Combined interrupt |

## Verification
The vector table first raises lone events and then several at once, including the unused bit 8. It then clears status bits singly, as the 0xFF group and with all ones, which separates a full-word clear from a low-byte clear and shows that bit 9 outlives the byte clear. The mask is driven with zero words, single bits, all ones and the unused bit. This shows that written zeros keep the stored value and that the two ports are not swapped. Directed cases pit an event against a clear of the same bit, read the write-only ports, write the read-only mask view, and apply reset in the middle of the sequence.

// File: rtl/irq_event_capture_pkg.sv
package irq_event_capture_pkg;

    localparam int STAT_W = 10;
    localparam int DATA_W = 32;

    // positions that exist; bit 8 is a hole
    localparam logic [STAT_W-1:0] DEFINED_BITS = 10'b10_1111_1111;

    localparam int POS_DONE     = 0;
    localparam int POS_DATA     = 1;
    localparam int POS_NOACK    = 2;
    localparam int POS_TIMEOUT  = 3;
    localparam int POS_TGT_RDY  = 4;
    localparam int POS_RX_OVER  = 5;
    localparam int POS_TX_OVER  = 6;
    localparam int POS_RX_UNDER = 7;
    localparam int POS_ARB_LOST = 9;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_UNMASK = 2'd2,
        SEL_DOMASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              clr_stat;
        logic              unmask;
        logic              domask;
        logic [STAT_W-1:0] bits;
    } wr_cmd_t;

    function automatic logic is_defined(input int pos);
        return DEFINED_BITS[pos];
    endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_event_capture_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W
) (
    input  logic          wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] wr_data,
    output wr_cmd_t       cmd
);
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DW-1:SW];

    always_comb begin
        cmd          = '0;
        cmd.bits     = wr_data[SW-1:0];
        cmd.clr_stat = wr_en && (reg_sel_e'(reg_sel) == SEL_STATUS);
        cmd.unmask   = wr_en && (reg_sel_e'(reg_sel) == SEL_UNMASK);
        cmd.domask   = wr_en && (reg_sel_e'(reg_sel) == SEL_DOMASK);
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_event_capture_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter logic [SW-1:0] VALID = DEFINED_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] evt,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_bits,
    output logic [SW-1:0] status_q
);
    logic unused_hole;
    assign unused_hole = ^(evt & ~VALID) ^ ^(clr_bits & ~VALID);

    for (genvar i = 0; i < SW; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            logic clr;
            assign clr = clr_en && clr_bits[i];
            always_ff @(posedge clk) begin
                if (rst)
                    status_q[i] <= 1'b0;
                else if (evt[i])
                    status_q[i] <= 1'b1;    // event beats a same-cycle clear
                else if (clr)
                    status_q[i] <= 1'b0;
            end
        end else begin : g_hole
            assign status_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_event_capture_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter logic [SW-1:0] VALID = DEFINED_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [SW-1:0] bits,
    output logic [SW-1:0] mask_q
);
    logic unused_hole;
    assign unused_hole = ^(bits & ~VALID);

    for (genvar i = 0; i < SW; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    mask_q[i] <= 1'b1;
                else if (set_en && bits[i])
                    mask_q[i] <= 1'b1;
                else if (clr_en && bits[i])
                    mask_q[i] <= 1'b0;
            end
        end else begin : g_hole
            assign mask_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_event_capture.sv
module irq_event_capture
    import irq_event_capture_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W,
    parameter logic [SW-1:0] VALID = DEFINED_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] evt_i,
    input  logic [1:0]    reg_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq_o
);
    localparam int PAD_W = DW - SW;

    wr_cmd_t       cmd;
    logic [SW-1:0] status_q;
    logic [SW-1:0] mask_q;

    irq_wr_decode #(.DW(DW), .SW(SW)) u_dec (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    irq_status_bank #(.SW(SW), .VALID(VALID)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .clr_en   (cmd.clr_stat),
        .clr_bits (cmd.bits),
        .status_q (status_q)
    );

    irq_mask_bank #(.SW(SW), .VALID(VALID)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (cmd.domask),
        .clr_en (cmd.unmask),
        .bits   (cmd.bits),
        .mask_q (mask_q)
    );

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_STATUS: rd_data = {{PAD_W{1'b0}}, status_q};
            SEL_MASK:   rd_data = {{PAD_W{1'b0}}, mask_q};
            default:    rd_data = '0;
        endcase
    end

    assign irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/irq_event_capture_chk.sv
module irq_event_capture_chk
    import irq_event_capture_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W,
    parameter logic [SW-1:0] VALID = DEFINED_BITS
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] evt_i,
    input logic [1:0]    reg_sel,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] rd_data,
    input logic          irq_o,
    input logic [SW-1:0] status_q,
    input logic [SW-1:0] mask_q
);
    localparam logic [DW-1:0] VALID_W = {{(DW-SW){1'b0}}, VALID};

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R2

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_sel == SEL_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_STATUS) |=> ((status_q & $past(wr_data[SW-1:0] & ~evt_i)) == '0)); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (reg_sel == SEL_UNMASK || reg_sel == SEL_DOMASK)) |=> $stable(mask_q)); // R5

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_q != '0)); // R7

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~VALID_W) == '0); // R8

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_UNMASK || reg_sel == SEL_DOMASK) |-> (rd_data == '0)); // R9
endmodule

bind irq_event_capture irq_event_capture_chk #(.DW(DW), .SW(SW), .VALID(VALID)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_o    (irq_o),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_event_capture_tb.sv
module irq_event_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  evt_i = '0;
    logic [1:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    irq_event_capture u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [9:0]  evt;
        logic        wr;
        logic [1:0]  sel;
        logic [31:0] wd;
        logic [9:0]  exp_stat;
        logic [9:0]  exp_mask;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{10'h001, 1'b0, 2'd0, 32'h0000_0000, 10'h001, 10'h2FF, 1'b0}, // R2 lone event
        '{10'h300, 1'b0, 2'd0, 32'h0000_0000, 10'h201, 10'h2FF, 1'b0}, // R2 R8 bit 8 dropped
        '{10'h000, 1'b1, 2'd2, 32'h0000_0001, 10'h201, 10'h2FE, 1'b1}, // R5 R7 unmask bit 0
        '{10'h000, 1'b1, 2'd3, 32'h0000_0000, 10'h201, 10'h2FE, 1'b1}, // R6 zero word
        '{10'h000, 1'b1, 2'd0, 32'h0000_0001, 10'h200, 10'h2FE, 1'b0}, // R3 R7 clear bit 0
        '{10'h000, 1'b1, 2'd2, 32'hFFFF_FFFF, 10'h200, 10'h000, 1'b1}, // R5 unmask all
        '{10'h0FE, 1'b0, 2'd0, 32'h0000_0000, 10'h2FE, 10'h000, 1'b1}, // R2 many events
        '{10'h000, 1'b1, 2'd0, 32'h0000_00FF, 10'h200, 10'h000, 1'b1}, // R3 0xFF keeps bit 9
        '{10'h200, 1'b1, 2'd0, 32'h0000_0200, 10'h200, 10'h000, 1'b1}, // R4 event beats clear
        '{10'h004, 1'b1, 2'd0, 32'hFFFF_FFFF, 10'h004, 10'h000, 1'b1}, // R4 R3 full clear
        '{10'h000, 1'b1, 2'd3, 32'h0000_0004, 10'h004, 10'h004, 1'b0}, // R6 R7 mask bit 2
        '{10'h000, 1'b1, 2'd3, 32'h0000_0100, 10'h004, 10'h004, 1'b0}, // R8 hole write
        '{10'h000, 1'b1, 2'd0, 32'h0000_0000, 10'h004, 10'h004, 1'b0}, // R3 zero clear word
        '{10'h000, 1'b1, 2'd1, 32'h0000_0000, 10'h004, 10'h004, 1'b0}  // R9 mask view read-only
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_back(input string req, input logic [9:0] es,
                             input logic [9:0] em, input logic ei);
        reg_sel = 2'd0; #1;
        chk({req, " status"}, rd_data, {22'd0, es});
        chk({req, " irq"}, {31'd0, irq_o}, {31'd0, ei});
        reg_sel = 2'd1; #1;
        chk({req, " mask"}, rd_data, {22'd0, em});
    endtask

    task automatic step(input logic [9:0] ev, input logic w, input logic [1:0] s,
                        input logic [31:0] d);
        @(negedge clk);
        evt_i = ev; wr_en = w; reg_sel = s; wr_data = d;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_back("R1 reset", 10'h000, 10'h2FF, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].evt, VECS[i].wr, VECS[i].sel, VECS[i].wd);
            read_back($sformatf("vec%0d", i), VECS[i].exp_stat, VECS[i].exp_mask, VECS[i].exp_irq);
        end

        // R9: write-only ports read zero
        reg_sel = 2'd2; #1; chk("R9 unmask port read", rd_data, 32'h0);
        reg_sel = 2'd3; #1; chk("R9 mask port read", rd_data, 32'h0);

        // R8: bit 8 event alone leaves status unchanged
        step(10'h100, 1'b0, 2'd0, 32'h0);
        read_back("R8 hole event", 10'h004, 10'h004, 1'b0);

        // R7: unmask target-ready then raise it
        step(10'h000, 1'b1, 2'd2, 32'h0000_0010);
        step(10'h010, 1'b0, 2'd0, 32'h0);
        read_back("R7 unmasked source", 10'h014, 10'h004, 1'b1);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_back("R1 mid-run reset", 10'h000, 10'h2FF, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule